// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

The block is a register-mapped controller in front of a one-time-programmable fuse array. The array is modelled as a parameterized set of 32-bit words, and each word has its own permanent lock bit. Software reaches the controller through a simple 32-bit request bus. A set of control registers decides whether an access to the array is allowed to change it. Programming needs three things at once: a key value written to the key register, program supply and program enable turned on in the supply register, and a target word that is not locked. Programming can only set bits and never clears them.

The configuration register selects several modes. It can enable redundant double storage, where word n is paired with a partner word and both are written together. It can enable auto-check, which compares the stored word with the intended value after a write. It can select lock-on-write mode, and it can turn on the read supply. Every failed or suspect access is recorded in a sticky error-flag register. Software clears the flags by writing ones to a clear register. Everything resets to zero only on the power-on reset.

Top module: `otp_fuse_top`

## Requirements
- R1: Bus timing and reset state.
  - A request sampled with busValid high is answered by busReady high on the next cycle. busReady is low in every other cycle.
  - For a read, busRdData holds the read value while busReady is high.
  - After reset, busRdData is 0, and the registers, the fuse words and the lock bits are all 0.
- R2: Register map and read-back.
  - 0x0020 is the configuration register, bits [4:0]:
    - bit0: read supply on
    - bit1: auto-check
    - bit2: double storage
    - bit3: margin read, which is stored only
    - bit4: lock-on-write
  - 0x0024 is the error-flag register and is read only.
  - 0x0028 is the flag-clear register and reads as 0.
  - 0x002C is the key register, bits [15:0].
  - 0x0054 is the supply register:
    - bit0: program supply stage 1
    - bit1: program supply stage 2
    - bit2: program enable
  - Register bits that do not exist read as 0. Unmapped addresses read as 0 and ignore writes.
- R3: A write to fuse word n, at address 0x1000 + 4*n, programs only when both of these hold: the key register equals 0x8810, and the supply register equals 3'b111. Otherwise the word is left unchanged and error flag bit0 is set.
- R4: A programming write ORs the write data into the stored word. Stored bits never go from 1 to 0, and writing 0 leaves the word unchanged.
- R5: Double storage.
  - For DEPTH words, word n is paired with partner word n+DEPTH/2 when n < DEPTH/2, and with n-DEPTH/2 otherwise.
  - A programming write made with config bit2 set ORs the data into both the word and its partner.
  - A fuse read made with bit2 set returns the word ORed with its partner. With bit2 clear, the read returns the word alone.
- R6: A programming write made with config bit4 set locks the target word permanently and stores none of its data. No flag is set.
- R7: Any write to a locked word leaves the word unchanged and sets error flag bit1.
- R8: With config bit1 set, a programming write whose resulting stored word differs from the write data sets error flag bit2. The word is still updated.
- R9: A fuse read with config bit0 clear returns 0 and sets error flag bit3.
- R10: A fuse access whose word index (address bits [11:2]) is at least DEPTH sets error flag bit4 and has no other effect. A read of such an index returns 0.
- R11: Error flags.
  - Error flags are sticky.
  - Writing a mask to 0x0028 clears the flags whose mask bits are 1, within bits [13:0].
  - No flag clears in any other way.
  - For a write, the flag priority is bit4, then bit0, then bit1, then bit2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busValid | input | 1 | Request strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Response strobe, one cycle after the request |
| busRdData | output | 32 | Read data, valid while busReady is high after a read |

## Verification
The assertions check several rules on every cycle:
- the response timing;
- the zero data and flag set by a read with the supply off;
- the flag set by an out-of-range index;
- that flags never clear except through the clear register;
- that a lock bit persists while the same word stays addressed.

The bench scenarios cover what needs history or data comparison, each against a reference array model:
- the key and supply gate, swept over all supply values;
- set-only programming;
- the mapping of partner words in double storage;
- lock-on-write, and write rejection on locked words;
- auto-check mismatches;
- the partial flag clears.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 14;

  localparam logic [15:0] KEY_MAGIC = 16'h8810;

  localparam logic [ADDR_W-1:0] OFF_CFG   = 16'h0020;
  localparam logic [ADDR_W-1:0] OFF_FLAGS = 16'h0024;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 16'h0028;
  localparam logic [ADDR_W-1:0] OFF_KEY   = 16'h002C;
  localparam logic [ADDR_W-1:0] OFF_PWR   = 16'h0054;
  localparam logic [3:0]        ARRAY_NIB = 4'h1;

  // configuration bits
  localparam int CFG_RDSUP  = 0;
  localparam int CFG_CHECK  = 1;
  localparam int CFG_DOUBLE = 2;
  localparam int CFG_MARGIN = 3;
  localparam int CFG_LOCK   = 4;
  localparam int CFG_W      = 5;

  // supply register: stage1, stage2, program enable
  localparam int PWR_W = 3;

  // error flag bits
  localparam int ERR_GATE   = 0;
  localparam int ERR_LOCKED = 1;
  localparam int ERR_CHECK  = 2;
  localparam int ERR_RDOFF  = 3;
  localparam int ERR_RANGE  = 4;

  typedef struct packed {
    logic store;  // OR data into the addressed word
    logic lock;   // set the addressed word's lock bit
    logic dbl;    // also OR data into the partner word
  } fuseStrobe_t;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_fuse_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fuseStrobe_t       strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dblRead,
  output logic              wordLocked,
  output logic              checkMiss,
  output logic [DATA_W-1:0] rdWord
);
  localparam int HALF = DEPTH / 2;

  logic [DEPTH-1:0][DATA_W-1:0] fuseWords;
  logic [DEPTH-1:0]             lockBits;
  logic [IDX_W-1:0]             partnerIdx;
  logic [DATA_W-1:0]            curWord;
  logic [DATA_W-1:0]            partnerWord;

  always_comb begin
    if (wordIdx < IDX_W'(HALF)) partnerIdx = wordIdx + IDX_W'(HALF);
    else                        partnerIdx = wordIdx - IDX_W'(HALF);
  end

  assign curWord     = fuseWords[wordIdx];
  assign partnerWord = fuseWords[partnerIdx];
  assign wordLocked  = lockBits[wordIdx];
  assign checkMiss   = (curWord | wrData) != wrData;
  assign rdWord      = dblRead ? (curWord | partnerWord) : curWord;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic              hitMain;
    logic              hitCopy;
    logic [DATA_W-1:0] wordQ;
    logic              lockQ;

    assign hitMain = (wordIdx == IDX_W'(w));
    assign hitCopy = strobe.dbl && (partnerIdx == IDX_W'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ <= '0;
        lockQ <= 1'b0;
      end else begin
        if (strobe.store && (hitMain || hitCopy)) wordQ <= wordQ | wrData;
        if (strobe.lock && hitMain) lockQ <= 1'b1;
      end
    end

    assign fuseWords[w] = wordQ;
    assign lockBits[w]  = lockQ;
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              wordLocked,
  input  logic              checkMiss,
  input  logic [DATA_W-1:0] arrWord,
  output fuseStrobe_t       strobe,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              dblRead,
  output logic              busReady,
  output logic [DATA_W-1:0] busRdData,
  output logic [FLAG_W-1:0] errFlags,
  output logic [CFG_W-1:0]  cfgBits
);
  logic [15:0]       keyReg;
  logic [PWR_W-1:0]  pwrReg;
  logic [9:0]        fullIdx;
  logic              isArray, inRange, gateOk, arrWr, arrRd;
  logic [FLAG_W-1:0] errSet, errClr;
  logic [DATA_W-1:0] rdNext;

  assign isArray = busAddr[15:12] == ARRAY_NIB;
  assign fullIdx = busAddr[11:2];
  assign inRange = {22'd0, fullIdx} < 32'(DEPTH);
  assign wordIdx = fullIdx[IDX_W-1:0];
  assign gateOk  = (keyReg == KEY_MAGIC) && (pwrReg == 3'b111);
  assign arrWr   = busValid && busWe && isArray;
  assign arrRd   = busValid && !busWe && isArray;
  assign dblRead = cfgBits[CFG_DOUBLE];

  always_comb begin
    strobe.store = arrWr && inRange && gateOk && !wordLocked && !cfgBits[CFG_LOCK];
    strobe.lock  = arrWr && inRange && gateOk && !wordLocked &&  cfgBits[CFG_LOCK];
    strobe.dbl   = cfgBits[CFG_DOUBLE];
  end

  always_comb begin
    errSet = '0;
    if (arrWr) begin
      if (!inRange)      errSet[ERR_RANGE]  = 1'b1;
      else if (!gateOk)  errSet[ERR_GATE]   = 1'b1;
      else if (wordLocked) errSet[ERR_LOCKED] = 1'b1;
      else if (!cfgBits[CFG_LOCK] && cfgBits[CFG_CHECK] && checkMiss)
        errSet[ERR_CHECK] = 1'b1;
    end
    if (arrRd) begin
      if (!inRange)                errSet[ERR_RANGE] = 1'b1;
      else if (!cfgBits[CFG_RDSUP]) errSet[ERR_RDOFF] = 1'b1;
    end
  end

  assign errClr = (busValid && busWe && busAddr == OFF_CLR) ? busWdata[FLAG_W-1:0] : '0;

  always_comb begin
    rdNext = '0;
    if (isArray) begin
      if (inRange && cfgBits[CFG_RDSUP]) rdNext = arrWord;
    end else begin
      case (busAddr)
        OFF_CFG:   rdNext = {{(DATA_W-CFG_W){1'b0}}, cfgBits};
        OFF_FLAGS: rdNext = {{(DATA_W-FLAG_W){1'b0}}, errFlags};
        OFF_KEY:   rdNext = {16'd0, keyReg};
        OFF_PWR:   rdNext = {{(DATA_W-PWR_W){1'b0}}, pwrReg};
        default:   rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBits   <= '0;
      keyReg    <= '0;
      pwrReg    <= '0;
      errFlags  <= '0;
      busReady  <= 1'b0;
      busRdData <= '0;
    end else begin
      busReady <= busValid;
      errFlags <= (errFlags & ~errClr) | errSet;
      if (busValid && !busWe) busRdData <= rdNext;
      if (busValid && busWe) begin
        case (busAddr)
          OFF_CFG: cfgBits <= busWdata[CFG_W-1:0];
          OFF_KEY: keyReg  <= busWdata[15:0];
          OFF_PWR: pwrReg  <= busWdata[PWR_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_fuse_top.sv
module otp_fuse_top
  import otp_fuse_pkg::*;
#(
  parameter int DEPTH = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busReady,
  output logic [DATA_W-1:0] busRdData
);
  localparam int IDX_W = $clog2(DEPTH);

  fuseStrobe_t       strobe;
  logic [IDX_W-1:0]  wordIdx;
  logic              dblRead, wordLocked, checkMiss;
  logic [DATA_W-1:0] arrWord;
  logic [FLAG_W-1:0] errFlags;
  logic [CFG_W-1:0]  cfgBits;

  otp_fuse_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .wordLocked(wordLocked),
    .checkMiss(checkMiss), .arrWord(arrWord), .strobe(strobe),
    .wordIdx(wordIdx), .dblRead(dblRead), .busReady(busReady),
    .busRdData(busRdData), .errFlags(errFlags), .cfgBits(cfgBits)
  );

  otp_fuse_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .wrData(busWdata), .dblRead(dblRead), .wordLocked(wordLocked),
    .checkMiss(checkMiss), .rdWord(arrWord)
  );
endmodule

// File: rtl/otp_fuse_checker.sv
module otp_fuse_checker #(
  parameter int DEPTH = 96,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busWe,
  input logic [15:0]      busAddr,
  input logic             busReady,
  input logic [31:0]      busRdData,
  input logic [13:0]      errFlags,
  input logic [4:0]       cfgBits,
  input logic             wordLocked,
  input logic [IDX_W-1:0] wordIdx
);
  logic arrayHit, outOfRange;
  assign arrayHit   = busValid && busAddr[15:12] == 4'h1;
  assign outOfRange = {22'd0, busAddr[11:2]} >= 32'(DEPTH);

  p_ready_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> busReady);

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !busReady);

  p_read_off_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (arrayHit && !busWe && !outOfRange && !cfgBits[0]) |=> (busRdData == 32'd0 && errFlags[3]));

  p_range_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (arrayHit && outOfRange) |=> errFlags[4]);

  p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWe && busAddr == 16'h0028) |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    wordLocked |=> (wordLocked || wordIdx != $past(wordIdx)));
endmodule

bind otp_fuse_top otp_fuse_checker #(.DEPTH(DEPTH)) u_check (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWe(busWe),
  .busAddr(busAddr), .busReady(busReady), .busRdData(busRdData),
  .errFlags(errFlags), .cfgBits(cfgBits), .wordLocked(wordLocked),
  .wordIdx(wordIdx)
);

// File: tb/otp_fuse_top_bench.sv
module otp_fuse_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int HALF = DEPTH / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWe = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model
  logic [31:0] refMem [DEPTH];
  logic        refLock [DEPTH];
  logic [13:0] refFlags = '0;
  logic [4:0]  refCfg = '0;
  logic [15:0] refKey = '0;
  logic [2:0]  refPwr = '0;

  localparam logic [15:0] A_CFG = 16'h0020, A_FLG = 16'h0024, A_CLR = 16'h0028,
                          A_KEY = 16'h002C, A_PWR = 16'h0054;

  otp_fuse_top #(.DEPTH(DEPTH)) u_otp_fuse_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
    .busRdData(busRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] wAddr(input int i);
    return 16'h1000 + 16'(i * 4);
  endfunction

  function automatic int partnerOf(input int i);
    return (i < HALF) ? i + HALF : i - HALF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    busValid = 1'b1; busWe = we; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWe = 1'b0;
    chk("R1 ready", {31'd0, busReady}, 32'd1);
    r = busRdData;
  endtask

  task automatic modelWrite(input logic [15:0] a, input logic [31:0] d);
    int fi;
    logic [31:0] nw;
    fi = int'(a[11:2]);
    if (a[15:12] == 4'h1) begin
      if (fi >= DEPTH) refFlags[4] = 1'b1;
      else if (!(refKey == 16'h8810 && refPwr == 3'b111)) refFlags[0] = 1'b1;
      else if (refLock[fi]) refFlags[1] = 1'b1;
      else if (refCfg[4]) refLock[fi] = 1'b1;
      else begin
        nw = refMem[fi] | d;
        if (refCfg[1] && nw != d) refFlags[2] = 1'b1;
        refMem[fi] = nw;
        if (refCfg[2]) refMem[partnerOf(fi)] = refMem[partnerOf(fi)] | d;
      end
    end else begin
      case (a)
        A_CFG: refCfg = d[4:0];
        A_CLR: refFlags = refFlags & ~d[13:0];
        A_KEY: refKey = d[15:0];
        A_PWR: refPwr = d[2:0];
        default: ;
      endcase
    end
  endtask

  task automatic modelRead(input logic [15:0] a, output logic [31:0] e);
    int fi;
    fi = int'(a[11:2]);
    e = '0;
    if (a[15:12] == 4'h1) begin
      if (fi >= DEPTH) refFlags[4] = 1'b1;
      else if (!refCfg[0]) refFlags[3] = 1'b1;
      else e = refCfg[2] ? (refMem[fi] | refMem[partnerOf(fi)]) : refMem[fi];
    end else begin
      case (a)
        A_CFG: e = {27'd0, refCfg};
        A_FLG: e = {18'd0, refFlags};
        A_KEY: e = {16'd0, refKey};
        A_PWR: e = {29'd0, refPwr};
        default: e = '0;
      endcase
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r;
    modelWrite(a, d);
    access(1'b1, a, d, r);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    logic [31:0] e, r;
    modelRead(a, e);
    access(1'b0, a, 32'd0, r);
    chk(tag, r, e);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin refMem[i] = '0; refLock[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", busRdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state of registers
    rd(A_CFG, "R1 cfg");
    rd(A_FLG, "R1 flags");
    rd(A_KEY, "R1 key");
    rd(A_PWR, "R1 pwr");

    // R2 register map
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, "R2 cfg");
    wr(A_KEY, 32'h1234_5678); rd(A_KEY, "R2 key");
    wr(A_PWR, 32'h0000_00FF); rd(A_PWR, "R2 pwr");
    rd(A_CLR, "R2 clr");
    wr(16'h0040, 32'hDEAD_BEEF); rd(16'h0040, "R2 unmapped");
    wr(A_KEY, 32'd0);
    wr(A_CFG, 32'h1);
    // R1 every fuse word zero after reset
    for (int i = 0; i < DEPTH; i++) rd(wAddr(i), "R1 word");

    // R3 gate sweep over key and all supply values
    for (int k = 0; k < 3; k++) begin
      wr(A_KEY, (k == 0) ? 32'h0 : (k == 1) ? 32'h8811 : 32'h8810);
      for (int p = 0; p < 8; p++) begin
        wr(A_PWR, 32'(p));
        wr(wAddr(p), 32'h1 << (p + 8 * k));
        rd(wAddr(p), "R3 word");
        rd(A_FLG, "R3 flags");
        wr(A_CLR, 32'h3FFF);
      end
    end

    // R4 set-only programming on every word
    wr(A_KEY, 32'h8810); wr(A_PWR, 32'h7);
    for (int i = 0; i < DEPTH; i++) begin
      wr(wAddr(i), 32'h1111_0000 << i);
      wr(wAddr(i), 32'h0000_0F0F ^ 32'(i));
      rd(wAddr(i), "R4 or");
      wr(wAddr(i), 32'h0);
      rd(wAddr(i), "R4 zero");
    end
    rd(A_FLG, "R4 flags");

    // R8 auto-check
    wr(A_CFG, 32'h3);
    wr(wAddr(0), refMem[0] | 32'h8000_0000);
    rd(A_FLG, "R8 match");
    wr(wAddr(0), 32'h1);
    rd(A_FLG, "R8 miss");
    rd(wAddr(0), "R8 word");
    wr(A_CLR, 32'h3FFF);

    // R5 double storage with partner word
    wr(A_CFG, 32'h5);
    wr(wAddr(1), 32'h00C0_0000);
    wr(A_CFG, 32'h1);
    rd(wAddr(1), "R5 main");
    rd(wAddr(1 + HALF), "R5 copy");
    wr(wAddr(1 + HALF), 32'h4000_0000);
    rd(wAddr(1), "R5 single");
    wr(A_CFG, 32'h5);
    rd(wAddr(1), "R5 double");
    rd(wAddr(6), "R5 double hi");

    // R6 lock-on-write, R7 locked word rejects writes
    wr(A_CFG, 32'h11);
    wr(wAddr(2), 32'hFFFF_FFFF);
    rd(A_FLG, "R6 flags");
    wr(A_CFG, 32'h1);
    rd(wAddr(2), "R6 word");
    wr(wAddr(2), 32'h0100_0000);
    rd(wAddr(2), "R7 word");
    rd(A_FLG, "R7 flags");
    wr(A_CFG, 32'h11);
    wr(wAddr(2), 32'h1);
    rd(A_FLG, "R7 relock");
    wr(A_CFG, 32'h1);
    rd(wAddr(3), "R6 neighbour");

    // R9 read with supply off
    wr(A_CLR, 32'h3FFF);
    wr(A_CFG, 32'h0);
    rd(wAddr(3), "R9 data");
    rd(A_FLG, "R9 flags");
    wr(A_CFG, 32'h1);

    // R10 index beyond depth (low index bits alias word 0)
    wr(wAddr(DEPTH), 32'hFFFF_FFFF);
    rd(wAddr(0), "R10 no effect");
    rd(A_FLG, "R10 flags");
    rd(wAddr(DEPTH), "R10 read");
    rd(16'h1FFC, "R10 top");

    // R11 partial clear and priority (range over gate)
    wr(A_KEY, 32'h0);
    wr(wAddr(0), 32'h2);
    wr(wAddr(DEPTH + 1), 32'h2);
    rd(A_FLG, "R11 set");
    wr(A_CLR, 32'h0011);
    rd(A_FLG, "R11 partial");
    wr(A_CLR, 32'hFFFF_C000);
    rd(A_FLG, "R11 high mask");
    wr(A_CLR, 32'h3FFF);
    rd(A_FLG, "R11 all");

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule